// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Multiplexed Address Bus

This block sits between a requester and a small behavioural DRAM array. The array is a grid of multi-bit supercells, four rows by four columns of eight bits by default. The requester issues single-word reads and writes, each carrying a row index, a column index, a write flag and write data. The controller reaches the array through one narrow address bus that it shares in time between the two indices. A row strobe carries the row index and copies the whole row into an internal row buffer. A column strobe then carries the column index and reads or updates one supercell in that buffer.

The controller keeps the last row open. A later access to the same row needs only a column strobe. An access to another row first writes the buffer back to the array, then opens the new row. Writes change only the row buffer, and the buffer reaches the array when the row is closed. A free-running timer requests a refresh at a fixed interval of clock cycles. When the controller is idle it closes any open row and then sweeps every row once, reading it into the buffer and writing it back.

Requests use a valid/ready handshake. The requester keeps `req_valid` and its fields stable until it sees `req_ready` high at a rising edge. The controller drops `req_ready` while an access or a refresh is in progress, and also while a refresh is pending. Read data comes back as a one-cycle `rsp_valid` pulse. The response path has no back-pressure, so the requester must take the data in that cycle.

Top module: `pgdram_ctrl`

## Requirements
- R1: Out of reset, `req_ready` is high, `strb_row`, `strb_col` and `rsp_valid` are low, `mux_addr` is 0, no row is open, the refresh timer is at zero, and every supercell reads as 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access ends. It rises again in the cycle after the column strobe for a write, and in the cycle after `rsp_valid` for a read.
- R3: When no row is open, `strb_row` is high with `mux_addr` equal to the row index in the cycle after acceptance. `strb_col` is high with `mux_addr` equal to the column index T_RCD cycles after that. Outside strobe cycles `mux_addr` is 0.
- R4: When the request's row is the open row, `strb_col` is high with the column index in the cycle after acceptance, and `strb_row` stays low.
- R5: When a different row is open, the cycle after acceptance closes it with both strobes low. `strb_row` follows one cycle later, and `strb_col` follows T_RCD cycles after that.
- R6: A read produces `rsp_valid` high for exactly one cycle, T_CL cycles after its column strobe. `rsp_data` holds the supercell value in that cycle.
- R7: A read returns the value of the most recent write to the same row and column, or 0 if there has been none. This holds across row changes and refreshes.
- R8: A refresh becomes pending every REFRESH_CYCLES cycles counted from reset, and `req_ready` is low while it is pending. The refresh starts in the first idle cycle. It spends one cycle closing an open row, if there is one. It then raises `strb_row` for rows 0 up to ROWS-1 in ascending order, two cycles apart, with `mux_addr` equal to each row index and no column strobe. `req_ready` rises in the cycle after the last row is written back.
- R9: After a refresh no row is open, so the next request follows the R3 sequence.
- R10: `strb_row` and `strb_col` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller takes a request at this edge |
| req_row | input | ROW_W | Row index of the request |
| req_col | input | COL_W | Column index of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_data | output | WORD_W | Read data, meaningful while rsp_valid is high |
| strb_row | output | 1 | Row strobe to the array |
| strb_col | output | 1 | Column strobe to the array |
| mux_addr | output | ADDR_W | Shared address bus: row index on a row strobe, column index on a column strobe |

## Verification
Every result has a fixed due cycle relative to the edge A at which the request was accepted. On an open-row hit the column strobe falls in cycle A+1. With no row open it falls in A+1+T_RCD, and on a row change in A+2+T_RCD. Read data is due T_CL cycles after the column strobe. Refresh row strobes are due at two-cycle spacing from the first idle cycle after the timer fires. The bench works out these cycle numbers with its own counters and stores each expected strobe, address and response under its cycle number. It then compares every output at each falling edge, so an event that comes a cycle early or late fails in both the cycle it should have appeared and the cycle it actually appeared.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_OPEN,
    ST_RCD,
    ST_COL,
    ST_CL,
    ST_RSP,
    ST_RCLOSE,
    ST_RACT,
    ST_RWB
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgdram_cell_array.sv
module pgdram_cell_array #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              wb,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic [ROWS-1:0][COLS-1:0][WORD_W-1:0] cells;
  logic [COLS-1:0][WORD_W-1:0]           rowbuf;
  logic [ROW_W-1:0]                      buf_row;

  // Row strobe loads a row, column strobe touches one word of the buffer,
  // write-back returns the whole buffer to the row it came from.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells   <= '0;
      rowbuf  <= '0;
      buf_row <= '0;
      rdata   <= '0;
    end else begin
      if (row_stb) begin
        rowbuf  <= cells[addr[ROW_W-1:0]];
        buf_row <= addr[ROW_W-1:0];
      end
      if (wb) begin
        cells[buf_row] <= rowbuf;
      end
      if (col_stb) begin
        if (wr) rowbuf[addr[COL_W-1:0]] <= wdata;
        else    rdata <= rowbuf[addr[COL_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/pgdram_refresh_timer.sv
module pgdram_refresh_timer #(
  parameter int REFRESH_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic pending
);
  localparam int CNT_W = $clog2(REFRESH_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (cnt == CNT_W'(REFRESH_CYCLES - 1)) begin
      cnt     <= '0;
      pending <= 1'b1;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (done) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pgdram_sequencer.sv
module pgdram_sequencer
  import pgdram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CL   = 2,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = max2(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              refresh_pending,
  output logic              refresh_done,
  output logic              row_stb,
  output logic              col_stb,
  output logic              wb,
  output logic              wr,
  output logic [ADDR_W-1:0] mux_addr,
  output logic [WORD_W-1:0] wdata_out,
  output logic              rsp_valid
);
  localparam int WAIT_W = $clog2(max2(T_RCD, T_CL) + 1);

  seq_state_e        state;
  logic [ROW_W-1:0]  lat_row;
  logic [ROW_W-1:0]  open_row;
  logic [ROW_W-1:0]  ref_row;
  logic [COL_W-1:0]  lat_col;
  logic              lat_we;
  logic [WORD_W-1:0] lat_wdata;
  logic              open_vld;
  logic [WAIT_W-1:0] wcnt;
  logic              accept;

  assign req_ready    = (state == ST_IDLE) && !refresh_pending;
  assign accept       = req_valid && req_ready;
  assign refresh_done = (state == ST_RWB) && (ref_row == ROW_W'(ROWS - 1));
  assign wdata_out    = lat_wdata;
  assign rsp_valid    = (state == ST_RSP);

  always_comb begin
    row_stb  = (state == ST_OPEN) || (state == ST_RACT);
    col_stb  = (state == ST_COL);
    wb       = (state == ST_CLOSE) || (state == ST_RCLOSE) || (state == ST_RWB);
    wr       = col_stb && lat_we;
    mux_addr = '0;
    case (state)
      ST_OPEN: mux_addr = ADDR_W'(lat_row);
      ST_RACT: mux_addr = ADDR_W'(ref_row);
      ST_COL:  mux_addr = ADDR_W'(lat_col);
      default: mux_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
      open_row  <= '0;
      open_vld  <= 1'b0;
      ref_row   <= '0;
      wcnt      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (refresh_pending) begin
            ref_row <= '0;
            state   <= open_vld ? ST_RCLOSE : ST_RACT;
          end else if (accept) begin
            lat_row   <= req_row;
            lat_col   <= req_col;
            lat_we    <= req_write;
            lat_wdata <= req_wdata;
            if (open_vld && open_row == req_row) state <= ST_COL;
            else if (open_vld)                   state <= ST_CLOSE;
            else                                 state <= ST_OPEN;
          end
        end
        ST_CLOSE: begin
          open_vld <= 1'b0;
          state    <= ST_OPEN;
        end
        ST_OPEN: begin
          open_vld <= 1'b1;
          open_row <= lat_row;
          if (T_RCD <= 1) state <= ST_COL;
          else begin
            wcnt  <= WAIT_W'(1);
            state <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (wcnt == WAIT_W'(T_RCD - 1)) state <= ST_COL;
          else wcnt <= wcnt + WAIT_W'(1);
        end
        ST_COL: begin
          if (lat_we) state <= ST_IDLE;
          else if (T_CL <= 1) state <= ST_RSP;
          else begin
            wcnt  <= WAIT_W'(1);
            state <= ST_CL;
          end
        end
        ST_CL: begin
          if (wcnt == WAIT_W'(T_CL - 1)) state <= ST_RSP;
          else wcnt <= wcnt + WAIT_W'(1);
        end
        ST_RSP: state <= ST_IDLE;
        ST_RCLOSE: begin
          open_vld <= 1'b0;
          state    <= ST_RACT;
        end
        ST_RACT: state <= ST_RWB;
        ST_RWB: begin
          if (ref_row == ROW_W'(ROWS - 1)) state <= ST_IDLE;
          else begin
            ref_row <= ref_row + ROW_W'(1);
            state   <= ST_RACT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int ROWS           = 4,
  parameter int COLS           = 4,
  parameter int WORD_W         = 8,
  parameter int T_RCD          = 2,
  parameter int T_CL           = 2,
  parameter int REFRESH_CYCLES = 1000,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = max2(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              strb_row,
  output logic              strb_col,
  output logic [ADDR_W-1:0] mux_addr
);
  logic              ref_pending;
  logic              ref_done;
  logic              wb;
  logic              wr;
  logic [WORD_W-1:0] arr_wdata;

  pgdram_refresh_timer #(
    .REFRESH_CYCLES(REFRESH_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (ref_done),
    .pending(ref_pending)
  );

  pgdram_sequencer #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .WORD_W(WORD_W),
    .T_RCD (T_RCD),
    .T_CL  (T_CL)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_row        (req_row),
    .req_col        (req_col),
    .req_write      (req_write),
    .req_wdata      (req_wdata),
    .refresh_pending(ref_pending),
    .refresh_done   (ref_done),
    .row_stb        (strb_row),
    .col_stb        (strb_col),
    .wb             (wb),
    .wr             (wr),
    .mux_addr       (mux_addr),
    .wdata_out      (arr_wdata),
    .rsp_valid      (rsp_valid)
  );

  pgdram_cell_array #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .row_stb(strb_row),
    .col_stb(strb_col),
    .wb     (wb),
    .wr     (wr),
    .addr   (mux_addr),
    .wdata  (arr_wdata),
    .rdata  (rsp_data)
  );
endmodule

// File: rtl/pgdram_ctrl_sva.sv
module pgdram_ctrl_sva #(
  parameter int T_CL = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic strb_row,
  input logic strb_col
);
  int unsigned since_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_col <= T_CL + 1;
    else if (strb_col) since_col <= 1;
    else if (since_col <= T_CL) since_col <= since_col + 1;
  end

  // R10
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_row && strb_col));

  // R6
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  p_rsp_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (since_col == T_CL));

  // R2
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  p_no_rsp_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind pgdram_ctrl pgdram_ctrl_sva #(.T_CL(T_CL)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .strb_row (strb_row),
  .strb_col (strb_col)
);

// File: tb/pgdram_ctrl_bench.sv
module pgdram_ctrl_bench;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int W     = 8;
  localparam int TRCD  = 2;
  localparam int TCL   = 2;
  localparam int RINT  = 150;
  localparam int LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_row = '0;
  logic [1:0] req_col = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       strb_row;
  logic       strb_col;
  logic [1:0] mux_addr;

  always #2 clk = ~clk;

  pgdram_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .WORD_W(W), .T_RCD(TRCD), .T_CL(TCL),
    .REFRESH_CYCLES(RINT)
  ) u_pgdram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .strb_row(strb_row), .strb_col(strb_col), .mux_addr(mux_addr)
  );

  int n_checks = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference state
  int mem_m [ROWS][COLS];
  int open_v = 0;
  int open_r = 0;
  int free_at = 0;
  int pend_m = 0;
  int ref_end = -1;
  int exp_row_at [int];
  int exp_col_at [int];
  int exp_rsp_at [int];
  int stim_q [$];   // bit 24 gap, bit 16 write, [13:12] row, [9:8] col, [7:0] data

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic push_req(input int we, input int r, input int c, input int d);
    stim_q.push_back((we << 16) | (r << 12) | (c << 8) | (d & 8'hff));
  endtask

  task automatic push_gap(input int k);
    for (int i = 0; i < k; i++) stim_q.push_back(1 << 24);
  endtask

  task automatic step();
    int ready_e, ea, er, ec, ers, head, r, c, cstart, k;
    ready_e = ((cyc >= free_at) && (pend_m == 0)) ? 1 : 0;
    er  = exp_row_at.exists(cyc) ? 1 : 0;
    ec  = exp_col_at.exists(cyc) ? 1 : 0;
    ers = exp_rsp_at.exists(cyc) ? 1 : 0;
    ea  = er ? exp_row_at[cyc] : (ec ? exp_col_at[cyc] : 0);
    if (cyc == 0) begin
      check("R1 reset ready", int'(req_ready), 1);
      check("R1 reset strobes", int'({strb_row, strb_col}), 0);
      check("R1 reset rsp_valid", int'(rsp_valid), 0);
    end
    check("R2,R8 req_ready", int'(req_ready), ready_e);
    check("R3,R5,R8,R9 strb_row", int'(strb_row), er);
    check("R3,R4,R5 strb_col", int'(strb_col), ec);
    check("R3,R8 mux_addr", int'(mux_addr), ea);
    check("R6 rsp_valid", int'(rsp_valid), ers);
    if (ers != 0) check("R6,R7 rsp_data", int'(rsp_data), exp_rsp_at[cyc]);

    // stimulus for the edge that ends this cycle
    req_valid = 1'b0;
    if (stim_q.size() != 0) begin
      head = stim_q[0];
      if (head[24]) begin
        void'(stim_q.pop_front());
      end else begin
        r = (head >> 12) & 3;
        c = (head >> 8) & 3;
        req_valid = 1'b1;
        req_row   = 2'(r);
        req_col   = 2'(c);
        req_write = head[16];
        req_wdata = head[7:0];
        if (ready_e != 0) begin
          void'(stim_q.pop_front());
          if (open_v != 0 && open_r == r) cstart = cyc + 1;
          else if (open_v != 0) begin
            exp_row_at[cyc + 2] = r;
            cstart = cyc + 2 + TRCD;
          end else begin
            exp_row_at[cyc + 1] = r;
            cstart = cyc + 1 + TRCD;
          end
          exp_col_at[cstart] = c;
          open_v = 1;
          open_r = r;
          if (head[16]) begin
            mem_m[r][c] = head & 8'hff;
            free_at = cstart + 1;
          end else begin
            exp_rsp_at[cstart + TCL] = mem_m[r][c];
            free_at = cstart + TCL + 1;
          end
        end
      end
    end
    if (ready_e == 0 && cyc >= free_at && pend_m != 0) begin
      k = open_v;
      for (int i = 0; i < ROWS; i++) exp_row_at[cyc + 1 + k + 2 * i] = i;
      free_at = cyc + 1 + k + 2 * ROWS;
      ref_end = free_at;
      open_v = 0;
    end
    if ((cyc % RINT) == RINT - 1) pend_m = 1;
    else if (cyc + 1 == ref_end) pend_m = 0;
  endtask

  initial begin
    int unsigned seed;
    int v;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mem_m[r][c] = 0;
    // directed: closed row, hit, row change with write-back, re-open
    push_req(0, 1, 2, 0);      // R3 closed row, unwritten word reads 0
    push_req(1, 1, 2, 8'hA5);  // R4 hit write
    push_req(0, 1, 2, 0);      // R4 hit read
    push_req(1, 3, 0, 8'h3C);  // R5 row change
    push_req(0, 1, 2, 0);      // R5, R7 back to row 1
    push_gap(5);
    push_req(0, 1, 3, 0);
    push_req(0, 3, 0, 0);
    seed = 32'h1234_5678;
    for (int i = 0; i < 320; i++) begin
      seed = seed * 1103515245 + 12345;
      v = int'(seed >> 8);
      if ((v % 5) == 0) push_gap((v >> 4) & 3);
      else push_req((v >> 3) & 1, (v >> 5) & 3, (v >> 7) & 3, (v >> 11) & 8'hff);
    end
    push_gap(2 * RINT);        // idle refresh, then R9 re-open
    push_req(0, 3, 0, 0);
    push_req(0, 1, 2, 0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(stim_q.size() == 0 && cyc > free_at + 2) && cyc < LIMIT) begin
      step();
      @(negedge clk);
      cyc++;
    end
    if (cyc >= LIMIT) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
    end
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule